// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block is a bus-attached peripheral that offers three byte-wide general-purpose ports, named A, B and C, to a host processor. The host configures the ports by writing a control byte and then moves data by writing to or reading from the port addresses. Each port has an input bus from its pins, an output bus towards its pins, and a per-bit drive enable that stands in for a tri-state pad. Port C can act as one byte-wide port, or as two nibbles whose directions are set separately.

Only the basic I/O mode is implemented. Each port, or each half of port C, is either an input or an output. Output data is latched and held after the write. Input data is passed through live to the host read bus. A control write whose top bit is clear sets or clears one bit of port C without disturbing the others. The group mode fields of the configuration word are decoded and stored, but they have no effect on port behaviour.

The host bus uses a clocked write, an asynchronous read, and an output enable for the read data. After reset every port is an input and needs no further setup.

Top module: `ppio_ctrl`

## Requirements
- R1: While reset is high and after reset is released, every drive enable is 0 (all ports are inputs), and every output bus is 0.
- R2: The two address bits select the target of an access: 2'b00 is port A, 2'b01 is port B, 2'b10 is port C, and 2'b11 is the control register.
- R3: A control write with data bit 7 = 1 loads the configuration. Bit 4 sets the port A direction and bit 1 sets the port B direction, where 1 means input. From the next cycle, an output port drives all 8 enable bits high and an input port drives them all low.
- R4: In that same word, bit 3 sets the direction of port C bits 7..4 and bit 0 sets the direction of port C bits 3..0, with 1 meaning input. The two halves take effect independently.
- R5: Loading a configuration word clears the A, B and C output latches to 0.
- R6: A control write with bit 7 = 0 writes bit 0 into the port C latch bit indexed by bits 3..1. All other latch bits stay unchanged, and bits 6..4 have no effect.
- R7: A port write latches the data on that port's output bus at the clock edge of the write. The value is held until the next write, bit operation or configuration load that affects the port.
- R8: Reading a port or half-port configured as input returns the live value on its input pins in the same cycle, without latching.
- R9: Reading an output port returns its latched value. A port C read combines each half from either its latch or its pins, according to that half's direction.
- R10: A read at the control address does not drive the read bus (output enable 0).
- R11: The read output enable is 1 only while chip select and read are both high and a port address is selected. Otherwise it is 0.
- R12: A write strobe with chip select low changes no latch and no configuration.
- R13: The group A mode bits (6..5) and group B mode bit (2) are stored, but they do not change the drive enables, the outputs or the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, sampled at the clock edge |
| addr_i | input | 2 | Target select: A, B, C or control |
| din_i | input | 8 | Host write data |
| dout_o | output | 8 | Host read data |
| dout_oe_o | output | 1 | Drive enable for the host read data |
| pa_in_i | input | 8 | Port A pin inputs |
| pa_out_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A per-bit drive enable |
| pb_in_i | input | 8 | Port B pin inputs |
| pb_out_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B per-bit drive enable |
| pc_in_i | input | 8 | Port C pin inputs |
| pc_out_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C per-bit drive enable |

## Verification
Writes, bit operations and configuration loads take effect at the clock edge that samples the write strobe. The bench drives every write on a falling edge, lets one rising edge pass, and compares the port outputs and enables at the following falling edge. Reads have no register in their path, so the bench sets the address and strobes, waits one time unit, and samples the read bus and its enable in that same cycle, with the pin inputs already set. The sweep covers all 128 configuration words and all 16 bit-operation codes, and the expected values come from a small bench model of the latches and directions.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    localparam int PORT_W    = 8;
    localparam int HALF_W    = PORT_W / 2;
    localparam int BIT_IDX_W = $clog2(PORT_W);
    localparam int NUM_PORTS = 3;
    localparam int ADDR_W    = 2;
    localparam int CFG_W     = PORT_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } port_sel_e;

    // Field order follows the configuration word, bit 6 down to bit 0.
    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       a_in;
        logic       cu_in;
        logic       grp_b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        grp_a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
        grp_b_mode: 1'b0,  b_in: 1'b1, cl_in: 1'b1
    };

    typedef struct packed {
        logic [NUM_PORTS-1:0] port_wr;
        logic                 mode_ld;
        logic                 bit_ld;
        logic [BIT_IDX_W-1:0] bit_idx;
        logic                 bit_val;
        logic                 rd_en;
        port_sel_e            sel;
    } bus_req_t;

    // Per-bit input mask of a port: 1 means the bit is an input.
    function automatic logic [PORT_W-1:0] in_mask(input cfg_t c, input int p);
        logic [PORT_W-1:0] m;
        case (p)
            0:       m = {PORT_W{c.a_in}};
            1:       m = {PORT_W{c.b_in}};
            default: m = {{HALF_W{c.cu_in}}, {HALF_W{c.cl_in}}};
        endcase
        return m;
    endfunction

    function automatic logic [PORT_W-1:0] merge_rd(
        input logic [PORT_W-1:0] mask,
        input logic [PORT_W-1:0] latch,
        input logic [PORT_W-1:0] pins
    );
        return (pins & mask) | (latch & ~mask);
    endfunction

endpackage

// File: rtl/ppio_bus_dec.sv
module ppio_bus_dec
    import ppio_pkg::*;
(
    input  logic                 cs,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 ctl_msb,
    input  logic [BIT_IDX_W:0]   ctl_lo,
    output bus_req_t             req
);

    logic wr_hit;
    logic ctrl_hit;

    assign wr_hit   = cs && wr;
    assign ctrl_hit = (port_sel_e'(addr) == SEL_CTRL);

    always_comb begin
        req         = '0;
        req.sel     = port_sel_e'(addr);
        for (int p = 0; p < NUM_PORTS; p++) begin
            req.port_wr[p] = wr_hit && (int'(addr) == p);
        end
        req.mode_ld = wr_hit && ctrl_hit && ctl_msb;
        req.bit_ld  = wr_hit && ctrl_hit && !ctl_msb;
        req.bit_idx = ctl_lo[BIT_IDX_W:1];
        req.bit_val = ctl_lo[0];
        req.rd_en   = cs && rd && !ctrl_hit;
    end

endmodule

// File: rtl/ppio_cfg.sv
module ppio_cfg
    import ppio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [CFG_W-1:0] word,
    output cfg_t             cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (ld) begin
            cfg_q <= cfg_t'(word);
        end
    end

    // R3 R4 R13
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cfg_q.grp_a_mode == $past(word[6:5]) &&
                cfg_q.grp_b_mode == $past(word[2]) &&
                cfg_q.a_in == $past(word[4]) && cfg_q.cu_in == $past(word[3]) &&
                cfg_q.b_in == $past(word[1]) && cfg_q.cl_in == $past(word[0])));

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(cfg_q));

endmodule

// File: rtl/ppio_latch.sv
module ppio_latch
    import ppio_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic             bit_wr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);

    logic [W-1:0] bit_sel;

    assign bit_sel = W'(1) << bit_idx;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata;
        end else if (bit_wr) begin
            q <= bit_val ? (q | bit_sel) : (q & ~bit_sel);
        end
    end

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    // R7
    wr_take_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> (q == $past(wdata)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr && !bit_wr) |=> $stable(q));

    // R6
    bit_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_wr && !wr && !clr) |=> (q[$past(bit_idx)] == $past(bit_val)));

    // R6
    bit_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_wr && !wr && !clr) |=>
            ((q & ~(W'(1) << $past(bit_idx))) == ($past(q) & ~(W'(1) << $past(bit_idx)))));

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PORT_W-1:0] din_i,
    output logic [PORT_W-1:0] dout_o,
    output logic              dout_oe_o,
    input  logic [PORT_W-1:0] pa_in_i,
    output logic [PORT_W-1:0] pa_out_o,
    output logic [PORT_W-1:0] pa_oe_o,
    input  logic [PORT_W-1:0] pb_in_i,
    output logic [PORT_W-1:0] pb_out_o,
    output logic [PORT_W-1:0] pb_oe_o,
    input  logic [PORT_W-1:0] pc_in_i,
    output logic [PORT_W-1:0] pc_out_o,
    output logic [PORT_W-1:0] pc_oe_o
);

    bus_req_t          req;
    cfg_t              cfg;
    logic [PORT_W-1:0] pin_in  [NUM_PORTS];
    logic [PORT_W-1:0] lat_q   [NUM_PORTS];
    logic [PORT_W-1:0] dir_in  [NUM_PORTS];
    logic [PORT_W-1:0] rd_val  [NUM_PORTS];

    ppio_bus_dec u_dec (
        .cs      (cs_i),
        .rd      (rd_i),
        .wr      (wr_i),
        .addr    (addr_i),
        .ctl_msb (din_i[PORT_W-1]),
        .ctl_lo  (din_i[BIT_IDX_W:0]),
        .req     (req)
    );

    ppio_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .ld    (req.mode_ld),
        .word  (din_i[CFG_W-1:0]),
        .cfg_q (cfg)
    );

    assign pin_in[0] = pa_in_i;
    assign pin_in[1] = pb_in_i;
    assign pin_in[2] = pc_in_i;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam bit HAS_BIT_OPS = (p == int'(SEL_C));

        ppio_latch #(.W(PORT_W)) u_lat (
            .clk     (clk),
            .rst     (rst),
            .clr     (req.mode_ld),
            .wr      (req.port_wr[p]),
            .wdata   (din_i),
            .bit_wr  (req.bit_ld && HAS_BIT_OPS),
            .bit_idx (req.bit_idx),
            .bit_val (req.bit_val),
            .q       (lat_q[p])
        );

        assign dir_in[p] = in_mask(cfg, p);
        assign rd_val[p] = merge_rd(dir_in[p], lat_q[p], pin_in[p]);
    end

    assign pa_out_o = lat_q[0];
    assign pb_out_o = lat_q[1];
    assign pc_out_o = lat_q[2];
    assign pa_oe_o  = ~dir_in[0];
    assign pb_oe_o  = ~dir_in[1];
    assign pc_oe_o  = ~dir_in[2];

    always_comb begin
        dout_o = '0;
        if (req.rd_en) begin
            case (req.sel)
                SEL_A:   dout_o = rd_val[0];
                SEL_B:   dout_o = rd_val[1];
                SEL_C:   dout_o = rd_val[2];
                default: dout_o = '0;
            endcase
        end
    end

    assign dout_oe_o = req.rd_en;

    // R1
    reset_dir_chk: assert property (@(posedge clk)
        rst |=> (pa_oe_o == '0 && pb_oe_o == '0 && pc_oe_o == '0 &&
                 pa_out_o == '0 && pb_out_o == '0 && pc_out_o == '0));

    // R11
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(cs_i && rd_i) |-> !dout_oe_o);

    // R10
    ctrl_noread_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_i && rd_i && addr_i == 2'b11) |-> !dout_oe_o);

    // R9
    rd_out_a_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_oe_o && addr_i == 2'b00 && pa_oe_o == '1) |-> (dout_o == pa_out_o));

    // R8
    rd_in_b_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_oe_o && addr_i == 2'b01 && pb_oe_o == '0) |-> (dout_o == pb_in_i));

    // R3 R4
    oe_half_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ($countones(pc_oe_o[7:4]) % 4 == 0 && $countones(pc_oe_o[3:0]) % 4 == 0));

endmodule

// File: tb/test_ppio_ctrl.sv
module test_ppio_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_chk = 0;
    int n_err = 0;

    // bench model
    logic [7:0] m_lat [3];
    logic       m_a_in, m_b_in, m_cu_in, m_cl_in;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ppio_ctrl i_ppio_ctrl (
        .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
        .din_i(din), .dout_o(dout), .dout_oe_o(dout_oe),
        .pa_in_i(pa_in), .pa_out_o(pa_out), .pa_oe_o(pa_oe),
        .pb_in_i(pb_in), .pb_out_o(pb_out), .pb_oe_o(pb_oe),
        .pc_in_i(pc_in), .pc_out_o(pc_out), .pc_oe_o(pc_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; wr = 1'b1; addr = a; din = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1;
        d = dout; oe = dout_oe;
        cs = 1'b0; rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd(input int p);
        logic [7:0] mask;
        logic [7:0] pins;
        case (p)
            0: begin mask = {8{m_a_in}}; pins = pa_in; end
            1: begin mask = {8{m_b_in}}; pins = pb_in; end
            default: begin mask = {{4{m_cu_in}}, {4{m_cl_in}}}; pins = pc_in; end
        endcase
        return (pins & mask) | (m_lat[p] & ~mask);
    endfunction

    task automatic check_outputs(input string req);
        chk(req, pa_out, m_lat[0]);
        chk(req, pb_out, m_lat[1]);
        chk(req, pc_out, m_lat[2]);
    endtask

    task automatic check_reads(input string req);
        logic [7:0] d;
        logic       oe;
        for (int p = 0; p < 3; p++) begin
            bus_read(2'(p), d, oe);
            chk(req, oe, 1'b1);
            chk(req, d, exp_rd(p));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic       oe;
        for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
        m_a_in = 1'b1; m_b_in = 1'b1; m_cu_in = 1'b1; m_cl_in = 1'b1;

        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", {pa_oe, pb_oe, pc_oe}, 24'h0);
        rst = 1'b0;
        @(negedge clk);
        // R1 after release
        chk("R1", {pa_oe, pb_oe, pc_oe}, 24'h0);
        check_outputs("R1");

        // R8 live inputs with no latching
        pa_in = 8'h3C; pb_in = 8'hA5; pc_in = 8'h81;
        check_reads("R8");
        pa_in = 8'hC3; pb_in = 8'h5A; pc_in = 8'h7E;
        check_reads("R8");

        // R3 R4 R5 R7 R9 R13 R2: sweep every configuration word
        for (int m = 0; m < 128; m++) begin
            // put data in the latches first so that the clear is visible
            bus_write(2'b00, 8'(m * 3 + 1));
            bus_write(2'b01, 8'(m * 5 + 2));
            bus_write(2'b10, 8'(m * 7 + 3));
            bus_write(2'b11, 8'h80 | 8'(m));
            m_a_in = m[4]; m_cu_in = m[3]; m_b_in = m[1]; m_cl_in = m[0];
            for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
            check_outputs("R5");
            chk("R3", pa_oe, {8{~m_a_in}});
            chk("R3", pb_oe, {8{~m_b_in}});
            chk("R4", pc_oe, {{4{~m_cu_in}}, {4{~m_cl_in}}});
            // R2: every write reaches its own port only
            bus_write(2'b00, 8'(m ^ 8'h96));
            m_lat[0] = 8'(m ^ 8'h96);
            bus_write(2'b01, 8'(m ^ 8'h69));
            m_lat[1] = 8'(m ^ 8'h69);
            bus_write(2'b10, 8'(~m));
            m_lat[2] = 8'(~m);
            check_outputs("R2 R7");
            pa_in = 8'(m * 11); pb_in = 8'(m * 13 + 7); pc_in = 8'(m * 17 + 5);
            // R13: group mode bits do not affect reads
            check_reads("R9 R13");
            repeat (2) @(negedge clk);
            check_outputs("R7");
        end

        // R6: bit operations on port C, with junk in bits 6..4
        bus_write(2'b11, 8'h80);
        m_a_in = 1'b0; m_b_in = 1'b0; m_cu_in = 1'b0; m_cl_in = 1'b0;
        for (int p = 0; p < 3; p++) m_lat[p] = 8'h00;
        bus_write(2'b00, 8'h5D);
        m_lat[0] = 8'h5D;
        bus_write(2'b01, 8'hE2);
        m_lat[1] = 8'hE2;
        for (int v = 1; v >= 0; v--) begin
            for (int i = 0; i < 8; i++) begin
                bus_write(2'b11, {1'b0, 3'(i * 3 + v), 3'(i), 1'(v)});
                m_lat[2][i] = 1'(v);
                check_outputs("R6");
            end
        end
        bus_write(2'b10, 8'hA6);
        m_lat[2] = 8'hA6;
        bus_write(2'b11, 8'h73);
        m_lat[2][1] = 1'b1;
        check_outputs("R6");
        bus_write(2'b11, 8'h7E);
        m_lat[2][7] = 1'b0;
        check_outputs("R6");

        // R12: writes without chip select are ignored
        bus_write(2'b00, 8'h11, 1'b0);
        bus_write(2'b10, 8'h22, 1'b0);
        bus_write(2'b11, 8'h9B, 1'b0);
        check_outputs("R12");
        chk("R12", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);

        // R10: a control read leaves the bus undriven
        bus_read(2'b11, d, oe);
        chk("R10", oe, 1'b0);

        // R11: read strobe without chip select, and chip select without read
        @(negedge clk);
        cs = 1'b0; rd = 1'b1; addr = 2'b00;
        #1;
        chk("R11", dout_oe, 1'b0);
        cs = 1'b1; rd = 1'b0;
        #1;
        chk("R11", dout_oe, 1'b0);
        cs = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule